// File: doc/BRIEF.md
# Page-Programmed Erase-Block Store

This block is a small storage array that follows the write rules of flash memory. Storage is split into erase blocks. Each block holds a power-of-two number of pages. Each page has a data area and a 16-byte spare area for check bytes, and the two areas are always moved together as one page word. A client issues one command at a time on a valid/ready port: page read, page program or block erase. There is no addressing of single bytes. Each accepted command returns a one-cycle done pulse with a 2-bit status. A successful read also returns the page word.

A program can only clear bits: the stored page becomes the old contents ANDed with the written word. Only a block erase sets bits back to one, and it acts on every page of the block, spare bytes included. Within a block, pages must be programmed in non-decreasing order, counted from the most recent erase. A page accepts at most `MAX_PROGS` programs between erases: 4 suits single-level use and 1 suits multi-level use. Any command that breaks a rule is rejected and leaves the store and all bookkeeping unchanged.

The controller is a four-state machine:
- IDLE: ready. IDLE->CHECK when a command is accepted.
- CHECK: the latched command is judged. Reads and programs take effect here. CHECK->ERASE on a legal erase, CHECK->RESP otherwise.
- ERASE: resets one page per cycle. ERASE->RESP after the last page.
- RESP: done is high. RESP->IDLE always.

Top module: `fstore_top`

## Requirements
- R1: After reset every page of every block reads as all ones, `cmd_ready` is 1 and `rsp_done` is 0.
- R2: A legal program (op 01) reports status 00, and the page then holds its previous word ANDed with `cmd_wdata` across data and spare bytes.
- R3: A legal erase (op 10) reports status 00 and sets every bit of every page of the addressed block to 1; other blocks keep their contents.
- R4: A program to a page below the highest page programmed in that block since its last erase is rejected with status 10 and changes nothing. Reprogramming that highest page, or any page above it, is allowed.
- R5: A page accepts at most `MAX_PROGS` (default 4) legal programs between erases. A further program to that page reports status 01 and changes nothing.
- R6: An erase clears the block's program counters and its order pointer, so any page of that block may then be programmed again, page 0 included.
- R7: A command whose block number is `NUM_BLOCKS` or above, or whose opcode is 11, reports status 11 and changes nothing.
- R8: A legal read (op 00) reports status 00 and returns the whole page word on `rsp_rdata`, which holds until the next legal read.
- R9: `cmd_ready` is high only in IDLE. Each accepted command yields exactly one `rsp_done` pulse of one cycle.
- R10: Counting the accepting edge as the first edge, `rsp_done` rises at the second edge for reads, programs and rejected commands, and at edge `PAGES_PER_BLOCK`+2 for a legal erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted when high together with cmd_valid |
| cmd_op | input | 2 | 00 read, 01 program, 10 erase, 11 invalid |
| cmd_block | input | BLK_AW | Erase block number |
| cmd_page | input | log2(PAGES_PER_BLOCK) | Page within the block (ignored by erase) |
| cmd_wdata | input | (PAGE_BYTES+SPARE_BYTES)*8 | Page word to program |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_status | output | 2 | 00 ok, 01 count exceeded, 10 out of order, 11 out of range |
| rsp_rdata | output | (PAGE_BYTES+SPARE_BYTES)*8 | Page word from the last legal read |

## Verification
The bench targets the following failure modes:
- **Overwrite instead of AND.** A store that overwrote a page would show set bits coming back after several partial programs of one page.
- **Erase limited to the data area.** An erase that missed the spare bytes would leave zeros in the upper bytes of the read word.
- **Stale bookkeeping after erase.** A design that kept the order pointer or counters across an erase would reject the program of page 0 that follows one.
- **Wrong limit or order test.** An off-by-one count limit, or an order check of strict greater-than, would show up in the fifth program to a page and in the reprogram of the highest page.
- **Rejected commands that leak.** A reject that still wrote the array would be exposed by the read that follows it.
- **Bad range decode.** Block 3 of three blocks and opcode 11 must come back with status 11.

// File: rtl/fstore_pkg.sv
package fstore_pkg;
    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_PROG  = 2'b01,
        OP_ERASE = 2'b10,
        OP_BAD   = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        ST_OK    = 2'b00,
        ST_COUNT = 2'b01,
        ST_ORDER = 2'b10,
        ST_RANGE = 2'b11
    } status_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_CHECK,
        S_ERASE,
        S_RESP
    } state_e;
endpackage

// File: rtl/fstore_rules.sv
module fstore_rules
    import fstore_pkg::*;
#(
    parameter int NUM_BLOCKS = 3,
    parameter int BLK_AW     = 2,
    parameter int PG_AW      = 2,
    parameter int CNT_W      = 3,
    parameter int MAX_PROGS  = 4
) (
    input  op_e               op,
    input  logic [BLK_AW-1:0] blk,
    input  logic [PG_AW-1:0]  page,
    input  logic              hi_valid,
    input  logic [PG_AW-1:0]  hi_page,
    input  logic [CNT_W-1:0]  cnt,
    output status_e           status
);
    localparam logic [BLK_AW:0]  NB   = NUM_BLOCKS[BLK_AW:0];
    localparam logic [CNT_W-1:0] MAXC = CNT_W'(MAX_PROGS);

    always_comb begin
        status = ST_OK;
        if (op == OP_BAD || {1'b0, blk} >= NB) begin
            status = ST_RANGE;
        end else if (op == OP_PROG) begin
            if (hi_valid && page < hi_page) begin
                status = ST_ORDER;
            end else if (cnt >= MAXC) begin
                status = ST_COUNT;
            end
        end
    end
endmodule

// File: rtl/fstore_meta.sv
module fstore_meta #(
    parameter int NUM_BLOCKS = 3,
    parameter int PAGES      = 4,
    parameter int BLK_AW     = 2,
    parameter int PG_AW      = 2,
    parameter int CNT_W      = 3,
    parameter int MAX_PROGS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BLK_AW-1:0] blk_i,
    input  logic [PG_AW-1:0]  page_i,
    input  logic              prog_en,
    input  logic              clr_en,
    output logic              hi_valid_o,
    output logic [PG_AW-1:0]  hi_page_o,
    output logic [CNT_W-1:0]  cnt_o
);
    localparam int ROWS  = NUM_BLOCKS * PAGES;
    localparam int ROW_W = BLK_AW + PG_AW;
    localparam logic [CNT_W-1:0] MAXC = CNT_W'(MAX_PROGS);

    logic             hv_q [NUM_BLOCKS];
    logic [PG_AW-1:0] hp_q [NUM_BLOCKS];
    logic [CNT_W-1:0] cnt_q [ROWS];
    logic [ROW_W-1:0] row;

    assign row = {blk_i, page_i};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int b = 0; b < NUM_BLOCKS; b++) begin
                hv_q[b] <= 1'b0;
                hp_q[b] <= '0;
            end
            for (int r = 0; r < ROWS; r++) begin
                cnt_q[r] <= '0;
            end
        end else begin
            for (int b = 0; b < NUM_BLOCKS; b++) begin
                if (clr_en && blk_i == BLK_AW'(b)) begin
                    hv_q[b] <= 1'b0;
                end else if (prog_en && blk_i == BLK_AW'(b)) begin
                    hv_q[b] <= 1'b1;
                    hp_q[b] <= page_i;
                end
            end
            for (int r = 0; r < ROWS; r++) begin
                if (clr_en && blk_i == BLK_AW'(r / PAGES)) begin
                    cnt_q[r] <= '0;
                end else if (prog_en && row == ROW_W'(r)) begin
                    cnt_q[r] <= cnt_q[r] + 1'b1;
                end
            end
        end
    end

    assign hi_valid_o = hv_q[blk_i];
    assign hi_page_o  = hp_q[blk_i];
    assign cnt_o      = cnt_q[row];

    // R6: an erase leaves the block with no order pointer
    p_erase_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> !hv_q[$past(blk_i)]);

    // R5: a granted program never pushes a counter past the limit
    p_count_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        prog_en |-> cnt_o < MAXC);
endmodule

// File: rtl/fstore_array.sv
module fstore_array #(
    parameter int ROWS      = 12,
    parameter int ROW_W     = 4,
    parameter int PAGE_BITS = 192
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ROW_W-1:0]     row,
    input  logic                 rd_en,
    input  logic                 prog_en,
    input  logic [PAGE_BITS-1:0] prog_data,
    input  logic                 ers_en,
    input  logic [ROW_W-1:0]     ers_row,
    output logic [PAGE_BITS-1:0] rdata
);
    logic [PAGE_BITS-1:0] mem [ROWS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) begin
                mem[r] <= '1;
            end
        end else begin
            for (int r = 0; r < ROWS; r++) begin
                if (ers_en && ers_row == ROW_W'(r)) begin
                    mem[r] <= '1;
                end else if (prog_en && row == ROW_W'(r)) begin
                    mem[r] <= mem[r] & prog_data;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '1;
        end else if (rd_en) begin
            rdata <= mem[row];
        end
    end

    // R2: after a program no bit is set where the written word had a zero
    p_and_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        prog_en |=> (mem[$past(row)] & ~$past(prog_data)) == '0);

    // R3: an erased row reads all ones
    p_erase_ones_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ers_en |=> &mem[$past(ers_row)]);
endmodule

// File: rtl/fstore_top.sv
module fstore_top
    import fstore_pkg::*;
#(
    parameter int NUM_BLOCKS      = 3,
    parameter int BLK_AW          = 2,
    parameter int PAGES_PER_BLOCK = 4,
    parameter int PAGE_BYTES      = 8,
    parameter int SPARE_BYTES     = 16,
    parameter int MAX_PROGS       = 4,
    localparam int PG_AW          = $clog2(PAGES_PER_BLOCK),
    localparam int PAGE_BITS      = (PAGE_BYTES + SPARE_BYTES) * 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    output logic                 cmd_ready,
    input  logic [1:0]           cmd_op,
    input  logic [BLK_AW-1:0]    cmd_block,
    input  logic [PG_AW-1:0]     cmd_page,
    input  logic [PAGE_BITS-1:0] cmd_wdata,
    output logic                 rsp_done,
    output logic [1:0]           rsp_status,
    output logic [PAGE_BITS-1:0] rsp_rdata
);
    localparam int ROWS  = NUM_BLOCKS * PAGES_PER_BLOCK;
    localparam int ROW_W = BLK_AW + PG_AW;
    localparam int CNT_W = $clog2(MAX_PROGS + 1);
    localparam logic [PG_AW-1:0] LAST_PG = PG_AW'(PAGES_PER_BLOCK - 1);
    localparam logic [BLK_AW:0]  NB      = NUM_BLOCKS[BLK_AW:0];

    state_e               state_q, state_d;
    op_e                  op_q;
    logic [BLK_AW-1:0]    blk_q, blk_c;
    logic [PG_AW-1:0]     page_q, ers_idx;
    logic [PAGE_BITS-1:0] data_q;
    status_e              st_q, rule_st;
    logic                 hv;
    logic [PG_AW-1:0]     hp;
    logic [CNT_W-1:0]     cnt;
    logic                 chk, rd_en, prog_en, clr_en, ers_en;

    generate
        if (NUM_BLOCKS == (1 << BLK_AW)) begin : g_full
            assign blk_c = blk_q;
        end else begin : g_clamp
            assign blk_c = ({1'b0, blk_q} < NB) ? blk_q : '0;
        end
    endgenerate

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (cmd_valid) state_d = S_CHECK;
            S_CHECK: state_d = (op_q == OP_ERASE && rule_st == ST_OK) ? S_ERASE : S_RESP;
            S_ERASE: if (ers_idx == LAST_PG) state_d = S_RESP;
            S_RESP:  state_d = S_IDLE;
        endcase
    end

    // outputs and strobes
    always_comb begin
        cmd_ready  = (state_q == S_IDLE);
        rsp_done   = (state_q == S_RESP);
        rsp_status = st_q;
        chk        = (state_q == S_CHECK);
        rd_en      = chk && op_q == OP_READ  && rule_st == ST_OK;
        prog_en    = chk && op_q == OP_PROG  && rule_st == ST_OK;
        clr_en     = chk && op_q == OP_ERASE && rule_st == ST_OK;
        ers_en     = (state_q == S_ERASE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q    <= OP_READ;
            blk_q   <= '0;
            page_q  <= '0;
            data_q  <= '1;
            st_q    <= ST_OK;
            ers_idx <= '0;
        end else begin
            if (state_q == S_IDLE && cmd_valid) begin
                op_q   <= op_e'(cmd_op);
                blk_q  <= cmd_block;
                page_q <= cmd_page;
                data_q <= cmd_wdata;
            end
            if (chk) begin
                st_q    <= rule_st;
                ers_idx <= '0;
            end
            if (ers_en) ers_idx <= ers_idx + 1'b1;
        end
    end

    fstore_rules #(
        .NUM_BLOCKS(NUM_BLOCKS), .BLK_AW(BLK_AW), .PG_AW(PG_AW),
        .CNT_W(CNT_W), .MAX_PROGS(MAX_PROGS)
    ) i_rules (
        .op(op_q), .blk(blk_q), .page(page_q),
        .hi_valid(hv), .hi_page(hp), .cnt(cnt), .status(rule_st)
    );

    fstore_meta #(
        .NUM_BLOCKS(NUM_BLOCKS), .PAGES(PAGES_PER_BLOCK), .BLK_AW(BLK_AW),
        .PG_AW(PG_AW), .CNT_W(CNT_W), .MAX_PROGS(MAX_PROGS)
    ) i_meta (
        .clk(clk), .rst_n(rst_n), .blk_i(blk_c), .page_i(page_q),
        .prog_en(prog_en), .clr_en(clr_en),
        .hi_valid_o(hv), .hi_page_o(hp), .cnt_o(cnt)
    );

    fstore_array #(
        .ROWS(ROWS), .ROW_W(ROW_W), .PAGE_BITS(PAGE_BITS)
    ) i_array (
        .clk(clk), .rst_n(rst_n), .row({blk_c, page_q}),
        .rd_en(rd_en), .prog_en(prog_en), .prog_data(data_q),
        .ers_en(ers_en), .ers_row({blk_c, ers_idx}), .rdata(rsp_rdata)
    );

    // R9: done lasts one cycle and is followed by ready
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done && cmd_ready);

    // R4: a granted program never lands below the block's order pointer
    p_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_en && hv) |-> page_q >= hp);
endmodule

// File: tb/test_fstore_top.sv
module test_fstore_top;
    localparam int NB = 3;
    localparam int P  = 4;
    localparam int PB = (8 + 16) * 8;
    localparam int NV = 37;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [1:0]    cmd_op = '0;
    logic [1:0]    cmd_block = '0;
    logic [1:0]    cmd_page = '0;
    logic [PB-1:0] cmd_wdata = '1;
    logic          rsp_done;
    logic [1:0]    rsp_status;
    logic [PB-1:0] rsp_rdata;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    logic [PB-1:0] ref_mem [NB*P];
    logic [1:0]    last_st;
    logic [PB-1:0] last_rd;
    int            last_lat;
    logic          last_busy_ready;

    // {op, block, page, pattern, expected status}
    localparam logic [11:0] VEC [NV] = '{
        {2'd1,2'd0,2'd0,4'd1,2'd0}, {2'd0,2'd0,2'd0,4'd0,2'd0},
        {2'd1,2'd0,2'd0,4'd2,2'd0}, {2'd0,2'd0,2'd0,4'd0,2'd0},
        {2'd1,2'd0,2'd2,4'd3,2'd0}, {2'd1,2'd0,2'd1,4'd1,2'd2},
        {2'd0,2'd0,2'd1,4'd0,2'd0}, {2'd1,2'd0,2'd2,4'd4,2'd0},
        {2'd1,2'd0,2'd2,4'd5,2'd0}, {2'd1,2'd0,2'd2,4'd6,2'd0},
        {2'd1,2'd0,2'd2,4'd7,2'd1}, {2'd0,2'd0,2'd2,4'd0,2'd0},
        {2'd1,2'd1,2'd3,4'd2,2'd0}, {2'd0,2'd3,2'd0,4'd0,2'd3},
        {2'd1,2'd3,2'd1,4'd1,2'd3}, {2'd2,2'd3,2'd0,4'd0,2'd3},
        {2'd3,2'd0,2'd0,4'd1,2'd3}, {2'd0,2'd0,2'd0,4'd0,2'd0},
        {2'd2,2'd0,2'd0,4'd0,2'd0}, {2'd0,2'd0,2'd0,4'd0,2'd0},
        {2'd0,2'd0,2'd2,4'd0,2'd0}, {2'd0,2'd1,2'd3,4'd0,2'd0},
        {2'd1,2'd0,2'd1,4'd3,2'd0}, {2'd1,2'd0,2'd0,4'd4,2'd2},
        {2'd0,2'd0,2'd1,4'd0,2'd0}, {2'd1,2'd0,2'd3,4'd5,2'd0},
        {2'd1,2'd0,2'd3,4'd6,2'd0}, {2'd0,2'd0,2'd3,4'd0,2'd0},
        {2'd2,2'd2,2'd1,4'd0,2'd0}, {2'd1,2'd2,2'd1,4'd8,2'd0},
        {2'd1,2'd2,2'd1,4'd9,2'd0}, {2'd1,2'd2,2'd1,4'd10,2'd0},
        {2'd1,2'd2,2'd1,4'd11,2'd0}, {2'd1,2'd2,2'd1,4'd12,2'd1},
        {2'd0,2'd2,2'd1,4'd0,2'd0}, {2'd1,2'd2,2'd0,4'd1,2'd2},
        {2'd0,2'd1,2'd3,4'd0,2'd0}
    };

    fstore_top i_fstore_top (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_block(cmd_block), .cmd_page(cmd_page),
        .cmd_wdata(cmd_wdata), .rsp_done(rsp_done), .rsp_status(rsp_status),
        .rsp_rdata(rsp_rdata)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    function automatic logic [PB-1:0] pat(input int id);
        logic [PB-1:0] r;
        for (int k = 0; k < PB / 8; k++) begin
            r[k*8 +: 8] = 8'((id * 53 + k * 29 + id * k * 7) ^ 8'h3C);
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [PB-1:0] act, input logic [PB-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] op, input logic [1:0] blk,
                         input logic [1:0] pg, input logic [PB-1:0] d);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_block = blk;
        cmd_page  = pg;
        cmd_wdata = d;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        last_busy_ready = cmd_ready;
        last_lat = 1;
        while (!rsp_done && last_lat < 100) begin
            @(negedge clk);
            last_lat++;
        end
        last_st = rsp_status;
        last_rd = rsp_rdata;
    endtask

    task automatic apply_ref(input logic [1:0] op, input logic [1:0] blk,
                             input logic [1:0] pg, input logic [PB-1:0] d);
        if (op == 2'd1) ref_mem[blk*P + pg] = ref_mem[blk*P + pg] & d;
        if (op == 2'd2) for (int q = 0; q < P; q++) ref_mem[blk*P + q] = '1;
    endtask

    function automatic string tag_of(input logic [1:0] op, input logic [1:0] st);
        if (st == 2'd3) return "R7";
        if (st == 2'd2) return "R4";
        if (st == 2'd1) return "R5";
        if (op == 2'd0) return "R8";
        if (op == 2'd2) return "R3";
        return "R2";
    endfunction

    initial begin
        for (int r = 0; r < NB*P; r++) ref_mem[r] = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle after reset
        check("R1 ready", PB'(cmd_ready), PB'(1));
        check("R1 done", PB'(rsp_done), PB'(0));
        for (int b = 0; b < NB; b++) begin
            for (int p = 0; p < P; p++) begin
                issue(2'd0, 2'(b), 2'(p), '1);
                check("R1 erased at reset", last_rd, '1);
            end
        end

        // table walk
        for (int i = 0; i < NV; i++) begin
            logic [1:0] op, blk, pg, st;
            logic [3:0] pid;
            {op, blk, pg, pid, st} = VEC[i];
            issue(op, blk, pg, pat(int'(pid)));
            check({tag_of(op, st), " status"}, PB'(last_st), PB'(st));
            if (op == 2'd0 && st == 2'd0)
                check({tag_of(op, st), " read data"}, last_rd, ref_mem[blk*P + pg]);
            if (st == 2'd0) apply_ref(op, blk, pg, pat(int'(pid)));
        end

        // R10: latency and R9: busy / single pulse
        issue(2'd0, 2'd1, 2'd3, '1);
        check("R10 read latency", PB'(last_lat), PB'(2));
        check("R9 ready low while busy", PB'(last_busy_ready), PB'(0));
        @(negedge clk);
        check("R9 done single cycle", PB'(rsp_done), PB'(0));
        check("R9 ready after done", PB'(cmd_ready), PB'(1));
        issue(2'd3, 2'd0, 2'd0, '1);
        check("R10 reject latency", PB'(last_lat), PB'(2));
        issue(2'd2, 2'd0, 2'd0, '1);
        apply_ref(2'd2, 2'd0, 2'd0, '1);
        check("R10 erase latency", PB'(last_lat), PB'(P + 2));

        // R6: after erase, page 0 and full count are available again
        for (int n = 0; n < 4; n++) begin
            issue(2'd1, 2'd0, 2'd0, pat(n + 1));
            check("R6 program after erase", PB'(last_st), PB'(0));
            apply_ref(2'd1, 2'd0, 2'd0, pat(n + 1));
        end
        issue(2'd0, 2'd0, 2'd0, '1);
        check("R6 data after erase", last_rd, ref_mem[0]);
        issue(2'd0, 2'd0, 2'd3, '1);
        check("R3 spare erased", last_rd, '1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule